// File: doc/BRIEF.md
# Three-Level Leg Modulator with Deep Carrier Overlap

This block turns a signed modulation sample into switch commands for one leg of a three-level neutral-point-clamped converter. A single up/down counter gives a pair of in-phase triangular carriers. The sample is compared against both carriers. The block then outputs one of three levels: positive rail (p), neutral (o) or negative rail (n). It also outputs the four gate commands of the leg. A strobe marks each carrier period.

The block has two modes. In the normal mode the carriers are stacked: the upper one spans [0, 1] and the lower one spans [-1, 0]. In the overlap mode both carriers are stretched toward each other by a depth h = D/N, where N is the counter peak. The upper carrier then spans [-h, 1] and the lower one spans [-1, h]. The vertical gap between the two carriers is always 1 - h. As a result the neutral level fills only about (1-h)/(1+h) of each period. The gain in the overlap region rises to 2/(1+h), so the sample is first multiplied by (1+h)/2 to compensate. The sample, the mode and the depth are taken at the valley of the counter and held for the whole period. The block also never lets a leg jump straight between the two rails. Dead time, measurement and control loops sit outside.

Top module: `dco_npc_modulator`

## Requirements
- R1: `level_o` codes n as 2'b00, o as 2'b01 and p as 2'b10. `gate_o` bit 0..3 drive switches T1..T4, outermost positive first. `gate_o` is 4'b0011 for p, 4'b0110 for o and 4'b1100 for n, always matching `level_o` in the same cycle.
- R2: In normal mode, with held sample m and counter value s (0..N, N = 2^FRAC_W), the level is p when m > s, n when m < s - N, and o otherwise.
- R3: In overlap mode, with held depth D and scaled sample m', the level is p when (m'+D)·N > s·(N+D), n when (m'+N)·N < s·(N+D), and o otherwise.
- R4: In overlap mode the held sample is m' = floor(m·(N+D)/(2N)), which cancels the raised gain 2N/(N+D). In normal mode m' = m.
- R5: The sample, the mode and the depth are taken only on the clock edge that leaves counter value 0. Input changes at any other time do not alter the period in progress.
- R6: The counter climbs 0..N and falls back to 0, so a period is 2N clocks. `period_stb_o` is high for exactly one cycle per period: the cycle after the counter sits at 0. `level_o` shows the decision for the counter value of the previous cycle.
- R7: Samples outside [-N, N] are saturated to the nearer bound before use.
- R8: The depth is saturated into [ceil(0.866·N), floor(0.97·N)], which is 14..15 for N = 16. In normal mode the depth has no effect.
- R9: When the newly decided level is the opposite rail from the current `level_o`, o is output for that cycle instead. The two outer switches are therefore never commanded together, and no p/n pair ever appears in consecutive cycles.
- R10: In overlap mode with a zero sample, the number of o cycles per period is within 2 of 2N·(N-D)/(N+D).
- R11: While reset is low, `level_o` is o, `gate_o` is 4'b0110 and `period_stb_o` is low. The first capture happens on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_i | input | MOD_W | Signed modulation sample, full scale ±2^FRAC_W |
| ovl_en_i | input | 1 | 1 selects deep-overlap mode, 0 selects stacked carriers |
| depth_i | input | DEPTH_W | Overlap depth D in units of 1/2^FRAC_W |
| level_o | output | 2 | Leg level code n/o/p |
| gate_o | output | 4 | Gate commands for T1..T4 |
| period_stb_o | output | 1 | One-cycle marker of a new carrier period |

## Verification
Stacked-carrier operation is swept over every sample value from -N to +N. This separates each threshold position on the rising and falling halves of the triangle. The same sweep is repeated in overlap mode at both ends of the legal depth range. Here the exact cycle where the level flips exposes any error in the gain scaling or in the carrier offset. Separate patterns cover the following:
- out-of-range samples and depths, to show saturation;
- inputs that change mid-period and are then restored before the valley, to prove that capture happens only at the valley;
- a small positive sample at the deepest overlap, which places the two rail thresholds on adjacent counter values and so forces the neutral insertion.

The neutral count per period at zero sample ties the depth to the resulting zero-level share.

// File: rtl/dco_npc_pkg.sv
package dco_npc_pkg;

    typedef enum logic [1:0] {
        LV_N = 2'b00,
        LV_O = 2'b01,
        LV_P = 2'b10
    } lvl_e;

    // Gate bit 0 is the outermost positive switch, bit 3 the outermost negative one.
    function automatic logic [3:0] lvl_gates(lvl_e lv);
        logic [3:0] g;
        case (lv)
            LV_P:    g = 4'b0011;
            LV_N:    g = 4'b1100;
            default: g = 4'b0110;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/dco_tri_counter.sv
module dco_tri_counter #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [FRAC_W:0]   cnt_o,
    output logic              valley_o,
    output logic              stb_o
);
    localparam int CNT_W = FRAC_W + 1;
    localparam int FULL  = 1 << FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
        logic             stb;
    } tri_t;

    tri_t cnt_q, cnt_d;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.stb = (cnt_q.cnt == '0);
        if (cnt_q.up) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
            if (cnt_q.cnt == CNT_W'(FULL - 1)) begin
                cnt_d.up = 1'b0;
            end
        end else begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
            if (cnt_q.cnt == CNT_W'(1)) begin
                cnt_d.up = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '{cnt: '0, up: 1'b1, stb: 1'b0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o    = cnt_q.cnt;
    assign valley_o = (cnt_q.cnt == '0);
    assign stb_o    = cnt_q.stb;

endmodule

// File: rtl/dco_sample_hold.sv
module dco_sample_hold #(
    parameter int FRAC_W  = 4,
    parameter int MOD_W   = FRAC_W + 2,
    parameter int DEPTH_W = FRAC_W + 1,
    parameter int H_LO    = 14,
    parameter int H_HI    = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture_i,
    input  logic signed [MOD_W-1:0]  mod_i,
    input  logic                     ovl_i,
    input  logic [DEPTH_W-1:0]       depth_i,
    output logic signed [FRAC_W+1:0] samp_o,
    output logic                     ovl_o,
    output logic [DEPTH_W-1:0]       depth_o
);
    localparam int SAMP_W = FRAC_W + 2;
    localparam int FULL   = 1 << FRAC_W;
    localparam int SHIFT  = FRAC_W + 1;

    typedef struct packed {
        logic signed [SAMP_W-1:0] samp;
        logic                     ovl;
        logic [DEPTH_W-1:0]       depth;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        int m_sat;
        int d_sat;
        int m_scl;
        hold_d = hold_q;

        m_sat = int'(mod_i);
        if (m_sat > FULL) begin
            m_sat = FULL;
        end else if (m_sat < -FULL) begin
            m_sat = -FULL;
        end

        d_sat = int'(depth_i);
        if (d_sat < H_LO) begin
            d_sat = H_LO;
        end else if (d_sat > H_HI) begin
            d_sat = H_HI;
        end

        // Overlap stretches the carriers, so shrink the sample by (N+D)/(2N).
        if (ovl_i) begin
            m_scl = (m_sat * (FULL + d_sat)) >>> SHIFT;
        end else begin
            m_scl = m_sat;
        end

        if (capture_i) begin
            hold_d.samp  = SAMP_W'(m_scl);
            hold_d.ovl   = ovl_i;
            hold_d.depth = DEPTH_W'(d_sat);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '{samp: '0, ovl: 1'b0, depth: DEPTH_W'(H_LO)};
        end else begin
            hold_q <= hold_d;
        end
    end

    assign samp_o  = hold_q.samp;
    assign ovl_o   = hold_q.ovl;
    assign depth_o = hold_q.depth;

endmodule

// File: rtl/dco_level_cmp.sv
module dco_level_cmp
    import dco_npc_pkg::*;
#(
    parameter int FRAC_W  = 4,
    parameter int DEPTH_W = FRAC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FRAC_W:0]          cnt_i,
    input  logic signed [FRAC_W+1:0] samp_i,
    input  logic                     ovl_i,
    input  logic [DEPTH_W-1:0]       depth_i,
    output lvl_e                     lvl_o,
    output logic [3:0]               gates_o
);
    localparam int FULL = 1 << FRAC_W;

    typedef struct packed {
        lvl_e       lvl;
        logic [3:0] gates;
    } leg_t;

    leg_t leg_q, leg_d;

    always_comb begin
        int   pos;
        int   smp;
        int   dep;
        int   carrier;
        int   top_cmp;
        int   bot_cmp;
        lvl_e raw;
        leg_d = leg_q;

        pos = int'(cnt_i);
        smp = int'(samp_i);
        dep = ovl_i ? int'(depth_i) : 0;

        // Both carriers are scaled by N so the comparison stays in integers.
        carrier = pos * (FULL + dep);
        top_cmp = (smp + dep) * FULL;
        bot_cmp = (smp + FULL) * FULL;

        if (top_cmp > carrier) begin
            raw = LV_P;
        end else if (bot_cmp < carrier) begin
            raw = LV_N;
        end else begin
            raw = LV_O;
        end

        leg_d.lvl = raw;
        if ((leg_q.lvl == LV_P && raw == LV_N) ||
            (leg_q.lvl == LV_N && raw == LV_P)) begin
            leg_d.lvl = LV_O;
        end
        leg_d.gates = lvl_gates(leg_d.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leg_q <= '{lvl: LV_O, gates: 4'b0110};
        end else begin
            leg_q <= leg_d;
        end
    end

    assign lvl_o   = leg_q.lvl;
    assign gates_o = leg_q.gates;

endmodule

// File: rtl/dco_npc_modulator.sv
module dco_npc_modulator
    import dco_npc_pkg::*;
#(
    parameter int FRAC_W   = 4,
    parameter int MOD_W    = FRAC_W + 2,
    parameter int DEPTH_W  = FRAC_W + 1,
    parameter int H_MIN_PM = 866,
    parameter int H_MAX_PM = 970
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [MOD_W-1:0] mod_i,
    input  logic                    ovl_en_i,
    input  logic [DEPTH_W-1:0]      depth_i,
    output logic [1:0]              level_o,
    output logic [3:0]              gate_o,
    output logic                    period_stb_o
);
    localparam int FULL    = 1 << FRAC_W;
    localparam int H_MIN_Q = (H_MIN_PM * FULL + 999) / 1000;
    localparam int H_MAX_Q = (H_MAX_PM * FULL) / 1000;

    logic [FRAC_W:0]          cnt_w;
    logic                     valley_w;
    logic signed [FRAC_W+1:0] samp_w;
    logic                     ovl_w;
    logic [DEPTH_W-1:0]       depth_w;
    lvl_e                     lvl_w;

    dco_tri_counter #(
        .FRAC_W (FRAC_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_o    (cnt_w),
        .valley_o (valley_w),
        .stb_o    (period_stb_o)
    );

    dco_sample_hold #(
        .FRAC_W  (FRAC_W),
        .MOD_W   (MOD_W),
        .DEPTH_W (DEPTH_W),
        .H_LO    (H_MIN_Q),
        .H_HI    (H_MAX_Q)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (valley_w),
        .mod_i     (mod_i),
        .ovl_i     (ovl_en_i),
        .depth_i   (depth_i),
        .samp_o    (samp_w),
        .ovl_o     (ovl_w),
        .depth_o   (depth_w)
    );

    dco_level_cmp #(
        .FRAC_W  (FRAC_W),
        .DEPTH_W (DEPTH_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_w),
        .samp_i  (samp_w),
        .ovl_i   (ovl_w),
        .depth_i (depth_w),
        .lvl_o   (lvl_w),
        .gates_o (gate_o)
    );

    assign level_o = lvl_w;

endmodule

// File: rtl/dco_npc_modulator_chk.sv
module dco_npc_modulator_chk #(
    parameter int FRAC_W   = 4,
    parameter int DEPTH_W  = FRAC_W + 1,
    parameter int H_MIN_PM = 866,
    parameter int H_MAX_PM = 970
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               level_o,
    input logic [3:0]               gate_o,
    input logic                     period_stb_o,
    input logic [FRAC_W:0]          cnt,
    input logic signed [FRAC_W+1:0] samp,
    input logic [DEPTH_W-1:0]       depth
);
    localparam int FULL    = 1 << FRAC_W;
    localparam int H_MIN_Q = (H_MIN_PM * FULL + 999) / 1000;
    localparam int H_MAX_Q = (H_MAX_PM * FULL) / 1000;

    p_gate_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate_o) == 2) && !(gate_o[0] && gate_o[3]));

    p_no_p_to_n_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 2'b10) |=> (level_o != 2'b00));

    p_no_n_to_p_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == 2'b00) |=> (level_o != 2'b10));

    p_stb_after_valley_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> period_stb_o);

    p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb_o |=> !period_stb_o);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= FULL);

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !period_stb_o |-> $stable(samp));

    p_samp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(samp) <= FULL) && (int'(samp) >= -FULL));

    p_depth_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(depth) >= H_MIN_Q) && (int'(depth) <= H_MAX_Q));

endmodule

bind dco_npc_modulator dco_npc_modulator_chk #(
    .FRAC_W   (FRAC_W),
    .DEPTH_W  (DEPTH_W),
    .H_MIN_PM (H_MIN_PM),
    .H_MAX_PM (H_MAX_PM)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_o      (level_o),
    .gate_o       (gate_o),
    .period_stb_o (period_stb_o),
    .cnt          (cnt_w),
    .samp         (samp_w),
    .depth        (depth_w)
);

// File: tb/dco_npc_modulator_tb_top.sv
module dco_npc_modulator_tb_top;
    localparam int K    = 4;
    localparam int N    = 1 << K;
    localparam int P    = 2 * N;
    localparam int MW   = K + 2;
    localparam int DW   = K + 1;
    localparam int HMIN = (866 * N + 999) / 1000;
    localparam int HMAX = (970 * N) / 1000;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic signed [MW-1:0] mod_i;
    logic                 ovl_en_i;
    logic [DW-1:0]        depth_i;
    logic [1:0]           level_o;
    logic [3:0]           gate_o;
    logic                 period_stb_o;

    always #5 clk = ~clk;

    dco_npc_modulator dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_i        (mod_i),
        .ovl_en_i     (ovl_en_i),
        .depth_i      (depth_i),
        .level_o      (level_o),
        .gate_o       (gate_o),
        .period_stb_o (period_stb_o)
    );

    int    checks = 0;
    int    errs   = 0;
    int    a_m;
    int    a_d;
    bit    a_ov;
    string a_tag;
    int    exp_prev;
    int    n_p, n_o, n_n;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Level codes per R1: n=0, o=1, p=2.
    function automatic int gates_of(int lv);
        if (lv == 2) return 3;
        if (lv == 0) return 12;
        return 6;
    endfunction

    // Expected level from R2, R3, R4, R7, R8, R9.
    function automatic int model(int m, bit ov, int d, int s, int prev);
        int mc = (m > N) ? N : ((m < -N) ? -N : m);
        int dc = (d < HMIN) ? HMIN : ((d > HMAX) ? HMAX : d);
        int me = ov ? ((mc * (N + dc)) >>> (K + 1)) : mc;
        int de = ov ? dc : 0;
        int raw;
        if ((me + de) * N > s * (N + de)) raw = 2;
        else if ((me + N) * N < s * (N + de)) raw = 0;
        else raw = 1;
        if ((prev == 2 && raw == 0) || (prev == 0 && raw == 2)) raw = 1;
        return raw;
    endfunction

    task automatic drive(int m, bit ov, int d);
        mod_i    = MW'(m);
        ovl_en_i = ov;
        depth_i  = DW'(d);
    endtask

    // Called right after a strobe cycle: queues new inputs and checks the period
    // that the previously queued inputs govern.
    task automatic run_period(int m, bit ov, int d, bit decoy, string tag);
        int s;
        int e;
        if (decoy) drive(11 - m, !ov, 0);
        else       drive(m, ov, d);
        n_p = 0; n_o = 0; n_n = 0;
        for (int i = 1; i <= P; i++) begin
            @(negedge clk);
            s = (i <= N) ? i : (P - i);
            e = model(a_m, a_ov, a_d, s, exp_prev);
            check(int'(level_o) == e, a_tag, int'(level_o), e);
            check(int'(gate_o) == gates_of(e), "R1", int'(gate_o), gates_of(e));
            check(period_stb_o == (i == P), "R6", int'(period_stb_o), int'(i == P));
            if (int'(level_o) == 2) n_p++;
            else if (int'(level_o) == 1) n_o++;
            else n_n++;
            exp_prev = e;
            if (decoy && i == N) drive(m, ov, d);
        end
        a_m = m; a_ov = ov; a_d = d; a_tag = tag;
    endtask

    task automatic zero_share(int d);
        int target = 2 * N * (N - d);
        int diff   = n_o * (N + d) - target;
        if (diff < 0) diff = -diff;
        check(diff <= 2 * (N + d), "R10", n_o, target / (N + d));
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0, 1'b0, HMIN);
        repeat (3) @(negedge clk);
        check(level_o == 2'b01, "R11", int'(level_o), 1);
        check(gate_o == 4'b0110, "R11", int'(gate_o), 6);
        check(period_stb_o == 1'b0, "R11", int'(period_stb_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(period_stb_o == 1'b1, "R11", int'(period_stb_o), 1);
        check(level_o == 2'b01, "R11", int'(level_o), 1);
        a_m = 0; a_ov = 1'b0; a_d = HMIN; a_tag = "R2"; exp_prev = 1;

        for (int m = -N; m <= N; m++) run_period(m, 1'b0, HMIN, 1'b0, "R2");
        run_period(31, 1'b0, HMIN, 1'b0, "R7");
        run_period(-32, 1'b0, HMIN, 1'b0, "R7");
        run_period(20, 1'b1, HMAX, 1'b0, "R7");
        run_period(-20, 1'b1, HMAX, 1'b0, "R7");
        for (int m = -N; m <= N; m++) run_period(m, 1'b1, HMAX, 1'b0, "R3");
        for (int m = -N; m <= N; m++) run_period(m, 1'b1, HMIN, 1'b0, "R4");
        run_period(2, 1'b1, HMAX, 1'b0, "R9");
        run_period(-2, 1'b1, HMAX, 1'b0, "R9");
        run_period(2, 1'b1, 0, 1'b0, "R8");
        run_period(2, 1'b1, 31, 1'b0, "R8");
        run_period(5, 1'b0, 0, 1'b0, "R8");
        run_period(5, 1'b1, HMAX, 1'b1, "R5");
        run_period(-7, 1'b0, HMIN, 1'b1, "R5");
        run_period(9, 1'b1, HMIN, 1'b1, "R5");
        run_period(0, 1'b1, HMAX, 1'b0, "R10");
        run_period(0, 1'b1, HMIN, 1'b0, "R10");
        zero_share(HMAX);
        run_period(0, 1'b0, HMIN, 1'b0, "R2");
        zero_share(HMIN);
        run_period(0, 1'b0, HMIN, 1'b0, "R2");

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule